// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block measures how many master-clock cycles make up one period of the left/right frame clock of an audio serial link. It then maps that count onto a fixed set of oversampling ratios: 128, 192, 256, 384, 512, 768 and 1152. The frame clock arrives asynchronously and is brought into the master-clock domain through a two-flop synchroniser. The block counts cycles between successive rising edges of the synchronised frame clock. Each completed period is classified with a tolerance of ±32 cycles, so jitter or phase wander on the master clock does not change the decision.

A ratio is reported only after two consecutive periods classify to the same ratio. The reported code then stays steady for as long as later periods stay inside that ratio's window. When a period matches no supported ratio, or when the frame clock stops for longer than the largest window, the block raises an unsupported flag and withdraws the valid flag.

All three outputs are plain levels that downstream clocking logic samples. There is no handshake and no back-pressure: a consumer that is not ready simply reads the levels later, and nothing is lost.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is low, and on the first cycle after it, `ratio_valid` = 0, `ratio_unsupported` = 0 and `ratio_code` = 0.
- R2: A measured period classifies by ratio code 0=128, 1=192, 2=256, 3=384, 4=512, 5=768, 6=1152. A count within the nominal value ±32 inclusive matches, and `ratio_code` never exceeds 6.
- R3: A count that lies in two windows (160 or 224) takes the lower ratio, so 160 gives code 0 and 224 gives code 1.
- R4: A period that matches no window (for example 95, 450, 640) sets `ratio_unsupported` = 1 and `ratio_valid` = 0. The next matching period clears `ratio_unsupported`.
- R5: The measured count equals the number of master-clock cycles between two successive synchronised rising edges of the frame clock. The first rising edge after reset only starts counting and produces no classification, however long it took to arrive.
- R6: `ratio_valid` rises only when a period classifies to the same code as the period directly before it. A single measured period never sets it.
- R7: An output change caused by a frame-clock rising edge appears on the third master-clock rising edge after the input rises: two synchroniser stages and one decision register.
- R8: While every period stays inside the locked ratio's window, including periods that alternate above and below the nominal value, `ratio_valid` stays 1 and `ratio_code` stays unchanged.
- R9: A matching period with a code different from the previous period clears `ratio_valid`. `ratio_code` keeps the last locked value until a new code has been seen twice in a row, and it changes only together with a high `ratio_valid`.
- R10: If more than 1184 cycles (largest nominal plus tolerance) pass after a rising edge with no new edge, `ratio_unsupported` goes to 1 and `ratio_valid` to 0 without waiting for an edge.
- R11: `ratio_valid` and `ratio_unsupported` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clk | input | 1 | Left/right frame clock, asynchronous to mclk |
| ratio_code | output | 3 | Last locked ratio code (0..6) |
| ratio_valid | output | 1 | High while a ratio is locked |
| ratio_unsupported | output | 1 | High after a period matched no ratio or the frame clock stalled |

## Verification
Every result is due on the third master-clock rising edge after the frame-clock input rises. The stimulus changes the frame clock on falling edges of the master clock, and the directed latency test reads the outputs on the second and third falling edges after a rise, so it sees the value just before the update and just after it. The table walk and the other directed tests read the outputs at the end of a whole frame, well after the last decision has settled. The stall test reads the outputs at about 1100 and about 1250 cycles after the last edge, on either side of the 1184-cycle limit.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  localparam int RATIO_COUNT = 7;
  localparam int MAX_RATIO   = 1152;

  typedef logic [2:0] ratio_code_t;

  localparam ratio_code_t CODE_NONE = 3'd7;

  // Nominal master-clock cycles per frame for each ratio code.
  function automatic int nominal_ratio(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      5:       return 768;
      default: return 1152;
    endcase
  endfunction

endpackage

// File: rtl/frame_edge_sync.sv
module frame_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic             armed_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_o <= 1'b0;
      count_o <= '0;
    end else begin
      if (rise_i) begin
        armed_o <= 1'b1;
        count_o <= CNT_W'(1);
      end else if (count_o != CNT_SAT) begin
        count_o <= count_o + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier #(
  parameter int CNT_W = 11,
  parameter int TOL   = 32
) (
  input  logic                [CNT_W-1:0] count_i,
  output logic                            hit_o,
  output mrd_pkg::ratio_code_t            code_o
);

  localparam int N = mrd_pkg::RATIO_COUNT;

  logic [31:0]  cnt32;
  logic [N-1:0] match;

  assign cnt32 = 32'(count_i);

  for (genvar g = 0; g < N; g++) begin : g_win
    localparam int LO = mrd_pkg::nominal_ratio(g) - TOL;
    localparam int HI = mrd_pkg::nominal_ratio(g) + TOL;
    assign match[g] = (cnt32 >= 32'(LO)) && (cnt32 <= 32'(HI));
  end

  // Lowest matching ratio wins where windows touch.
  always_comb begin
    hit_o  = 1'b0;
    code_o = mrd_pkg::CODE_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o  = 1'b1;
        code_o = 3'(i);
      end
    end
  end

endmodule

// File: rtl/lock_tracker.sv
module lock_tracker (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 period_done_i,
  input  logic                 hit_i,
  input  mrd_pkg::ratio_code_t code_i,
  input  logic                 stall_i,
  output logic                 valid_o,
  output logic                 unsup_o,
  output mrd_pkg::ratio_code_t code_o
);

  mrd_pkg::ratio_code_t cand_q;
  logic                 have_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      unsup_o <= 1'b0;
      code_o  <= '0;
      cand_q  <= '0;
      have_q  <= 1'b0;
    end else if (period_done_i) begin
      if (!hit_i) begin
        unsup_o <= 1'b1;
        valid_o <= 1'b0;
        have_q  <= 1'b0;
      end else begin
        unsup_o <= 1'b0;
        cand_q  <= code_i;
        have_q  <= 1'b1;
        if (have_q && (cand_q == code_i)) begin
          valid_o <= 1'b1;
          code_o  <= code_i;
        end else begin
          valid_o <= 1'b0;
        end
      end
    end else if (stall_i) begin
      unsup_o <= 1'b1;
      valid_o <= 1'b0;
      have_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect #(
  parameter int TOLERANCE   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       frame_clk,
  output logic [2:0] ratio_code,
  output logic       ratio_valid,
  output logic       ratio_unsupported
);

  localparam int LIMIT = mrd_pkg::MAX_RATIO + TOLERANCE;
  localparam int CNT_W = $clog2(LIMIT + 2);

  logic                 frame_rise;
  logic                 armed;
  logic [CNT_W-1:0]     count;
  logic                 hit;
  mrd_pkg::ratio_code_t cls_code;
  logic                 period_done;
  logic                 over_limit;

  frame_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (mclk),
    .rst_n    (rst_n),
    .async_in (frame_clk),
    .rise_o   (frame_rise)
  );

  period_counter #(.CNT_W(CNT_W)) u_count (
    .clk     (mclk),
    .rst_n   (rst_n),
    .rise_i  (frame_rise),
    .armed_o (armed),
    .count_o (count)
  );

  ratio_classifier #(.CNT_W(CNT_W), .TOL(TOLERANCE)) u_class (
    .count_i (count),
    .hit_o   (hit),
    .code_o  (cls_code)
  );

  assign period_done = frame_rise & armed;
  assign over_limit  = armed & (32'(count) > 32'(LIMIT));

  lock_tracker u_lock (
    .clk           (mclk),
    .rst_n         (rst_n),
    .period_done_i (period_done),
    .hit_i         (hit),
    .code_i        (cls_code),
    .stall_i       (over_limit),
    .valid_o       (ratio_valid),
    .unsup_o       (ratio_unsupported),
    .code_o        (ratio_code)
  );

endmodule

// File: rtl/mclk_ratio_detect_chk.sv
module mclk_ratio_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       period_done,
  input logic       over_limit,
  input logic [2:0] ratio_code,
  input logic       ratio_valid,
  input logic       ratio_unsupported
);

  // R11
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ratio_valid && ratio_unsupported));

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_code <= 3'd6);

  // R9
  code_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_code) |-> ratio_valid);

  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_valid) |-> $past(period_done));

  // R10
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ratio_valid) |-> ($past(period_done) || $past(over_limit)));

  // R4
  unsup_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_unsupported) |-> ($past(period_done) || $past(over_limit)));

endmodule

bind mclk_ratio_detect mclk_ratio_detect_chk u_chk (
  .clk               (mclk),
  .rst_n             (rst_n),
  .period_done       (period_done),
  .over_limit        (over_limit),
  .ratio_code        (ratio_code),
  .ratio_valid       (ratio_valid),
  .ratio_unsupported (ratio_unsupported)
);

// File: tb/mclk_ratio_detect_test.sv
module mclk_ratio_detect_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fin = 1'b0;
  logic [2:0] code;
  logic       valid;
  logic       unsup;

  int n_checks = 0;
  int n_err    = 0;

  always #2 clk = ~clk;

  mclk_ratio_detect uut (
    .mclk              (clk),
    .rst_n             (rst_n),
    .frame_clk         (fin),
    .ratio_code        (code),
    .ratio_valid       (valid),
    .ratio_unsupported (unsup)
  );

  // period, jitter, expected code, expected valid (0 means unsupported)
  localparam int ROWS = 17;
  localparam int T_N[ROWS]  = '{128, 192, 256, 384, 512, 768, 1152, 160, 224,
                                450, 96, 95, 1184, 1185, 768, 640, 1152};
  localparam int T_J[ROWS]  = '{0, 0, 0, 0, 0, 0, 0, 0, 0,
                                0, 0, 0, 0, 0, 20, 0, 30};
  localparam int T_C[ROWS]  = '{0, 1, 2, 3, 4, 5, 6, 0, 1,
                                0, 0, 0, 6, 0, 5, 0, 6};
  localparam int T_V[ROWS]  = '{1, 1, 1, 1, 1, 1, 1, 1, 1,
                                0, 1, 0, 1, 0, 1, 0, 1};

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  task automatic do_reset();
    fin   = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive_frame(input int n);
    fin = 1'b1;
    repeat (n / 2) @(negedge clk);
    fin = 1'b0;
    repeat (n - n / 2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 valid", int'(valid), 0);
    check("R1 unsupported", int'(unsup), 0);
    check("R1 code", int'(code), 0);

    // R5: long wait before the first edge is not classified
    repeat (1500) @(negedge clk);
    check("R5 no classification before first edge", int'(unsup), 0);

    // Table walk: R2, R3, R4, R5, R8, R10
    for (int r = 0; r < ROWS; r++) begin
      for (int k = 0; k < 4; k++) begin
        drive_frame(T_N[r] + ((k % 2 == 1) ? -T_J[r] : T_J[r]));
      end
      if (T_V[r] == 1) begin
        check($sformatf("R2/R3 row %0d valid", r), int'(valid), 1);
        check($sformatf("R2/R3 row %0d code", r), int'(code), T_C[r]);
        check($sformatf("R4 row %0d unsupported", r), int'(unsup), 0);
      end else begin
        check($sformatf("R4 row %0d unsupported", r), int'(unsup), 1);
        check($sformatf("R4 row %0d valid", r), int'(valid), 0);
      end
    end

    // R1 reset from a locked state
    do_reset();
    check("R1 valid after reset", int'(valid), 0);
    check("R1 code after reset", int'(code), 0);

    // R6 one measured period is not enough
    drive_frame(256);
    drive_frame(256);
    check("R6 single period valid", int'(valid), 0);
    check("R5 single period unsupported", int'(unsup), 0);

    // R7 latency: update on third mclk edge after the rise
    fin = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 before third edge", int'(valid), 0);
    @(negedge clk);
    check("R7 at third edge valid", int'(valid), 1);
    check("R7 at third edge code", int'(code), 2);
    repeat (125) @(negedge clk);
    fin = 1'b0;

    // R10 stall detection
    repeat (972) @(negedge clk);
    check("R10 still valid before limit", int'(valid), 1);
    repeat (150) @(negedge clk);
    check("R10 unsupported after stall", int'(unsup), 1);
    check("R10 valid after stall", int'(valid), 0);
    check("R9 code kept after stall", int'(code), 2);

    // R9 ratio change
    do_reset();
    drive_frame(256);
    drive_frame(256);
    drive_frame(256);
    drive_frame(512);
    fin = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 valid dropped on change", int'(valid), 0);
    check("R9 code retained", int'(code), 2);
    check("R9 no unsupported", int'(unsup), 0);
    repeat (253) @(negedge clk);
    fin = 1'b0;
    repeat (256) @(negedge clk);
    drive_frame(512);
    check("R9 relock valid", int'(valid), 1);
    check("R9 relock code", int'(code), 4);

    // R8 jitter around 384
    do_reset();
    drive_frame(384);
    drive_frame(384);
    drive_frame(384);
    for (int k = 0; k < 6; k++) begin
      drive_frame(384 + ((k % 2 == 0) ? 28 : -28));
      check("R8 jitter valid", int'(valid), 1);
      check("R8 jitter code", int'(code), 3);
    end

    finish_run();
  end

endmodule